// File: doc/BRIEF.md
# Status Byte Keeper and Write Permission Guard

This block sits between the command decoder of a serial non-volatile memory and its array sequencer. It holds the status byte (hardware-protect enable, two block-protect bits, the write-enable latch, and the write-in-progress flag), and it decides for every modifying request whether the request may start. The decoder presents one decoded command per pulse, together with a target address and, for a status write, the new status value. The guard answers one cycle later with a grant or a deny, and it updates its own state.

Array protection and status protection are controlled separately. The two block-protect bits close a region that grows downward from the top of the address space: the top quarter, the top half, or everything. The write-protect pin locks the status byte only while the enable bit is set. A status write runs its own self-timed cycle, and the stored bits change when that cycle ends. The array sequencer reports its own busy state through an input. The status byte is driven at all times, so it can be read in the middle of any internal cycle.

Top module: `status_guard`

## Requirements
- R1: After the power-on reset (`rst_n` low), every status bit is 0, including the non-volatile enable and block-protect bits.
- R2: The status byte holds the protect enable in bit 7, zeros in bits 6 to 4, block-protect high in bit 3, block-protect low in bit 2, the write-enable latch in bit 1 and write-in-progress in bit 0. A status write stores only data bits 7, 3 and 2. The other data bits are discarded.
- R3: Op 0 sets the write-enable latch and op 1 clears it. Both are always granted, whatever the protection state, the pin or the busy state.
- R4: While the latch is 0, every modifying request is denied: status write (op 2), array write (op 3), page erase (op 4), sector erase (op 5) and whole-array erase (op 6).
- R5: Array writes and page or sector erases are denied when the address lies in the protected region. Block-protect 00 protects nothing. 01 protects addresses whose two top bits are 11. 10 protects addresses whose top bit is 1. 11 protects all addresses.
- R6: A whole-array erase is denied whenever either block-protect bit is 1.
- R7: A status write is denied when the enable bit is 1 and `wp_n` is low. When the enable bit is 0, the pin has no effect.
- R8: A granted modifying request clears the latch. A denied request leaves the latch unchanged.
- R9: Every request is answered by a `resp_valid` pulse of exactly one cycle, in the cycle after `cmd_valid`. `resp_grant` carries the decision.
- R10: A granted status write holds bit 0 at 1 for STAT_CYCLES cycles. The new bits appear in the same cycle that bit 0 falls. A change on `wp_n` during that cycle does not alter the result.
- R11: Bit 0 is also 1 while `array_busy` is high. While bit 0 is 1, every modifying request is denied.
- R12: Op code 7 is answered with a deny and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cmd_valid | input | 1 | One-cycle request pulse |
| cmd_op | input | 3 | Decoded command code (see R3, R4, R12) |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_data | input | 8 | New status value for a status write |
| wp_n | input | 1 | Write-protect pin, low locks the status byte when enabled |
| array_busy | input | 1 | Array sequencer is running an internal cycle |
| resp_valid | output | 1 | Answer pulse |
| resp_grant | output | 1 | 1 = request may start, 0 = denied |
| stat_byte | output | 8 | Current status byte |

## Verification
The bench builds the guard with a 17-bit address and a timed status write of four cycles. This lets it walk every block-protect encoding at the exact boundary addresses of each region. Because the status cycle is short, a latch-set request, a refused array write and a pin toggle can all be placed inside a running status cycle. The bench then checks when bit 0 falls and when the new bits appear.

// File: rtl/sg_pkg.sv
package sg_pkg;

   typedef enum logic [2:0] {
      OP_WEN    = 3'd0,
      OP_WDIS   = 3'd1,
      OP_WRSTAT = 3'd2,
      OP_WRARR  = 3'd3,
      OP_ERPAGE = 3'd4,
      OP_ERSECT = 3'd5,
      OP_ERCHIP = 3'd6,
      OP_NONE   = 3'd7
   } sg_op_e;

   // status byte bit positions
   localparam int unsigned SB_WIP  = 0;
   localparam int unsigned SB_WEL  = 1;
   localparam int unsigned SB_BP0  = 2;
   localparam int unsigned SB_BP1  = 3;
   localparam int unsigned SB_WPEN = 7;

   // non-volatile field: {enable, bp1, bp0}
   typedef struct packed {
      logic       wpen;
      logic [1:0] bp;
   } sg_nv_t;

   function automatic logic sg_is_modify(sg_op_e op);
      return (op == OP_WRSTAT) || (op == OP_WRARR) || (op == OP_ERPAGE) ||
             (op == OP_ERSECT) || (op == OP_ERCHIP);
   endfunction

endpackage

// File: rtl/sg_region_check.sv
module sg_region_check #(
   parameter int unsigned ADDR_W = 17
) (
   input  logic [1:0]        bp,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int unsigned TOP = ADDR_W - 1;

   if (ADDR_W < 2) begin : g_bad_width
      $error("sg_region_check: ADDR_W must be at least 2");
   end

   logic [1:0] top_bits;
   logic [ADDR_W-3:0] addr_unused;
   assign top_bits    = addr[TOP -: 2];
   assign addr_unused = addr[ADDR_W-3:0];

   always_comb begin
      unique case (bp)
         2'b00:   hit = 1'b0;
         2'b01:   hit = &top_bits;
         2'b10:   hit = top_bits[1];
         default: hit = 1'b1;
      endcase
   end
endmodule

// File: rtl/sg_cycle_timer.sv
module sg_cycle_timer #(
   parameter int unsigned CYCLES = 8,
   parameter bit          TIMED  = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  sg_pkg::sg_nv_t start_val,
   output logic           busy,
   output logic           done,
   output sg_pkg::sg_nv_t done_val
);
   if (CYCLES < 1) begin : g_bad_cycles
      $error("sg_cycle_timer: CYCLES must be at least 1");
   end

   if (TIMED) begin : g_timed
      localparam int unsigned CW = $clog2(CYCLES + 1);
      localparam logic [CW-1:0] LOAD = CW'(CYCLES);
      localparam logic [CW-1:0] LAST = CW'(1);

      logic [CW-1:0]  cnt;
      sg_pkg::sg_nv_t pend;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt  <= '0;
            pend <= '0;
         end else if (start) begin
            cnt  <= LOAD;
            pend <= start_val;
         end else if (cnt != '0) begin
            cnt  <= cnt - LAST;
         end
      end

      assign busy     = (cnt != '0);
      assign done     = (cnt == LAST);
      assign done_val = pend;
   end else begin : g_direct
      logic clk_unused;
      assign clk_unused = clk ^ rst_n;
      assign busy     = 1'b0;
      assign done     = start;
      assign done_val = start_val;
   end
endmodule

// File: rtl/sg_permit.sv
module sg_permit (
   input  sg_pkg::sg_op_e op,
   input  logic           wel,
   input  logic           wip,
   input  logic           wpen,
   input  logic           wp_n,
   input  logic [1:0]     bp,
   input  logic           region_hit,
   output logic           grant
);
   import sg_pkg::*;

   logic ready;
   assign ready = wel & ~wip;

   always_comb begin
      unique case (op)
         OP_WEN, OP_WDIS:               grant = 1'b1;
         OP_WRSTAT:                     grant = ready & ~(wpen & ~wp_n);
         OP_WRARR, OP_ERPAGE, OP_ERSECT: grant = ready & ~region_hit;
         OP_ERCHIP:                     grant = ready & (bp == 2'b00);
         default:                       grant = 1'b0;
      endcase
   end
endmodule

// File: rtl/status_guard.sv
module status_guard #(
   parameter int unsigned ADDR_W      = 17,
   parameter int unsigned STAT_CYCLES = 8,
   parameter bit          STAT_TIMED  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [7:0]        cmd_data,
   input  logic              wp_n,
   input  logic              array_busy,
   output logic              resp_valid,
   output logic              resp_grant,
   output logic [7:0]        stat_byte
);
   import sg_pkg::*;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("status_guard: ADDR_W must be at least 2");
   end
   if (STAT_CYCLES < 1) begin : g_bad_cyc
      $error("status_guard: STAT_CYCLES must be at least 1");
   end

   sg_op_e  op;
   logic    wel;
   sg_nv_t  nv;
   sg_nv_t  new_nv;
   sg_nv_t  commit_nv;
   logic    stat_busy;
   logic    commit;
   logic    wip;
   logic    region_hit;
   logic    permit;
   logic    start_stat;
   logic    data_unused;

   assign op          = sg_op_e'(cmd_op);
   assign wip         = array_busy | stat_busy;
   assign new_nv      = '{wpen: cmd_data[SB_WPEN], bp: cmd_data[SB_BP1:SB_BP0]};
   assign data_unused = ^{cmd_data[6:4], cmd_data[1:0]};

   sg_region_check #(.ADDR_W(ADDR_W)) u_region (
      .bp   (nv.bp),
      .addr (cmd_addr),
      .hit  (region_hit)
   );

   sg_permit u_permit (
      .op         (op),
      .wel        (wel),
      .wip        (wip),
      .wpen       (nv.wpen),
      .wp_n       (wp_n),
      .bp         (nv.bp),
      .region_hit (region_hit),
      .grant      (permit)
   );

   assign start_stat = cmd_valid & permit & (op == OP_WRSTAT);

   sg_cycle_timer #(.CYCLES(STAT_CYCLES), .TIMED(STAT_TIMED)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_stat),
      .start_val (new_nv),
      .busy      (stat_busy),
      .done      (commit),
      .done_val  (commit_nv)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_grant <= 1'b0;
      end else begin
         resp_valid <= cmd_valid;
         resp_grant <= cmd_valid & permit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel <= 1'b0;
      end else if (cmd_valid) begin
         if (op == OP_WEN)                         wel <= 1'b1;
         else if (op == OP_WDIS)                   wel <= 1'b0;
         else if (sg_is_modify(op) && permit)      wel <= 1'b0;
      end
   end

   // power-on reset is the only clear of the non-volatile bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      nv <= '0;
      else if (commit) nv <= commit_nv;
   end

   always_comb begin
      stat_byte          = '0;
      stat_byte[SB_WPEN] = nv.wpen;
      stat_byte[SB_BP1]  = nv.bp[1];
      stat_byte[SB_BP0]  = nv.bp[0];
      stat_byte[SB_WEL]  = wel;
      stat_byte[SB_WIP]  = wip;
   end
endmodule

// File: rtl/sg_checker.sv
module sg_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [2:0] cmd_op,
   input logic       wp_n,
   input logic       array_busy,
   input logic       resp_valid,
   input logic       resp_grant,
   input logic [7:0] stat_byte
);
   logic is_mod;
   assign is_mod = (cmd_op >= 3'd2) && (cmd_op <= 3'd6);

   AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> resp_valid);                                               // R9
   AST_RESP_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !resp_valid);                                             // R9
   AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      stat_byte[6:4] == 3'b000);                                               // R2
   AST_LATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == 3'd0 |=> stat_byte[1] && resp_grant);             // R3
   AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == 3'd1 |=> !stat_byte[1] && resp_grant);            // R3
   AST_NO_LATCH_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && is_mod && !stat_byte[1] |=> !resp_grant);                   // R4
   AST_CHIP_BP_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == 3'd6 && stat_byte[3:2] != 2'b00 |=> !resp_grant); // R6
   AST_PIN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == 3'd2 && stat_byte[7] && !wp_n |=> !resp_grant);   // R7
   AST_GRANT_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && is_mod |=> (resp_grant -> !stat_byte[1]));                  // R8
   AST_BUSY_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && is_mod && stat_byte[0] |=> !resp_grant);                    // R11
   AST_ARRAY_BUSY_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
      array_busy |-> stat_byte[0]);                                            // R11
   AST_NULL_OP_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == 3'd7 |=> !resp_grant && $stable(stat_byte[7:1])); // R12
endmodule

bind status_guard sg_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_op     (cmd_op),
   .wp_n       (wp_n),
   .array_busy (array_busy),
   .resp_valid (resp_valid),
   .resp_grant (resp_grant),
   .stat_byte  (stat_byte)
);

// File: tb/sim_status_guard.sv
`timescale 1ns/100ps
module sim_status_guard;
   localparam int unsigned AW = 17;
   localparam int unsigned SC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_op = 3'd7;
   logic [AW-1:0] cmd_addr = '0;
   logic [7:0]    cmd_data = '0;
   logic          wp_n = 1'b1;
   logic          array_busy = 1'b0;
   logic          resp_valid, resp_grant;
   logic [7:0]    stat_byte;

   int    errors = 0;
   int    checks = 0;
   bit    done = 1'b0;
   bit    exp_q[$];
   string tag_q[$];

   status_guard #(.ADDR_W(AW), .STAT_CYCLES(SC), .STAT_TIMED(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n),
      .array_busy(array_busy), .resp_valid(resp_valid),
      .resp_grant(resp_grant), .stat_byte(stat_byte)
   );

   always #2.5 clk = ~clk;

   // monitor: pops one expectation per answer
   always @(negedge clk) begin
      if (rst_n && resp_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R9: unexpected answer grant=%0b expected none", resp_grant);
         end else begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (resp_grant !== e) begin
               errors++;
               $display("FAIL %s: grant=%0b expected %0b", t, resp_grant, e);
            end
         end
      end
   end

   task automatic send(input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [7:0] d, input bit exp, input string tag);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd7;
   endtask

   task automatic chk(input logic [7:0] exp, input string tag);
      checks++;
      if (stat_byte !== exp) begin
         errors++;
         $display("FAIL %s: status=%02h expected %02h", tag, stat_byte, exp);
      end
   endtask

   task automatic wsr(input logic [7:0] d, input logic [7:0] final_st);
      send(3'd0, '0, 8'h00, 1'b1, "R3");
      send(3'd2, '0, d, 1'b1, "R10");
      repeat (SC) @(negedge clk);
      chk(final_st, "R10");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(8'h00, "R1");

      send(3'd3, 17'h00000, 8'h00, 1'b0, "R4");
      send(3'd4, 17'h00000, 8'h00, 1'b0, "R4");
      send(3'd2, 17'h00000, 8'hFF, 1'b0, "R4");
      chk(8'h00, "R4");

      send(3'd0, '0, 8'h00, 1'b1, "R3");
      chk(8'h02, "R3");

      // status write of all ones: only bits 7,3,2 kept
      send(3'd2, '0, 8'hFF, 1'b1, "R10");
      chk(8'h01, "R8");
      repeat (SC - 1) @(negedge clk);
      chk(8'h01, "R10");
      @(negedge clk);
      chk(8'h8C, "R2");

      send(3'd0, '0, 8'h00, 1'b1, "R3");
      send(3'd3, 17'h00000, 8'h00, 1'b0, "R5");
      chk(8'h8E, "R8");
      send(3'd6, '0, 8'h00, 1'b0, "R6");

      wp_n = 1'b0;
      send(3'd2, '0, 8'h04, 1'b0, "R7");
      chk(8'h8E, "R7");
      send(3'd1, '0, 8'h00, 1'b1, "R3");
      chk(8'h8C, "R3");
      send(3'd0, '0, 8'h00, 1'b1, "R3");
      chk(8'h8E, "R3");

      // status write with pin toggled during the cycle
      wp_n = 1'b1;
      send(3'd2, '0, 8'h04, 1'b1, "R7");
      wp_n = 1'b0;
      send(3'd0, '0, 8'h00, 1'b1, "R3");
      chk(8'h8F, "R10");
      send(3'd3, 17'h00000, 8'h00, 1'b0, "R11");
      chk(8'h8F, "R11");
      repeat (SC - 2) @(negedge clk);
      chk(8'h06, "R10");

      // enable bit now 0: pin low has no effect
      send(3'd2, '0, 8'h08, 1'b1, "R7");
      repeat (SC) @(negedge clk);
      chk(8'h08, "R7");

      // bp=10: top half protected
      send(3'd0, '0, 8'h00, 1'b1, "R3");
      send(3'd3, 17'h0FFFF, 8'h00, 1'b1, "R5");
      chk(8'h08, "R8");
      send(3'd0, '0, 8'h00, 1'b1, "R3");
      send(3'd5, 17'h10000, 8'h00, 1'b0, "R5");
      send(3'd4, 17'h1FFFF, 8'h00, 1'b0, "R5");
      send(3'd6, '0, 8'h00, 1'b0, "R6");
      send(3'd4, 17'h0FF00, 8'h00, 1'b1, "R5");

      // bp=01: top quarter protected
      wsr(8'h04, 8'h04);
      send(3'd0, '0, 8'h00, 1'b1, "R3");
      send(3'd3, 17'h17FFF, 8'h00, 1'b1, "R5");
      send(3'd0, '0, 8'h00, 1'b1, "R3");
      send(3'd4, 17'h18000, 8'h00, 1'b0, "R5");
      send(3'd6, '0, 8'h00, 1'b0, "R6");

      // bp=00: nothing protected
      wp_n = 1'b1;
      send(3'd2, '0, 8'h00, 1'b1, "R10");
      repeat (SC) @(negedge clk);
      chk(8'h00, "R10");
      send(3'd0, '0, 8'h00, 1'b1, "R3");
      send(3'd6, '0, 8'h00, 1'b1, "R6");
      chk(8'h00, "R8");
      send(3'd0, '0, 8'h00, 1'b1, "R3");
      send(3'd3, 17'h1FFFF, 8'h00, 1'b1, "R5");

      // array busy
      send(3'd0, '0, 8'h00, 1'b1, "R3");
      array_busy = 1'b1;
      #0.1;
      chk(8'h03, "R11");
      send(3'd5, 17'h00000, 8'h00, 1'b0, "R11");
      array_busy = 1'b0;
      #0.1;
      chk(8'h02, "R11");

      // null op
      send(3'd7, 17'h00000, 8'hFF, 1'b0, "R12");
      chk(8'h02, "R12");

      @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R9: %0d answers missing expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule